// File: doc/BRIEF.md
# Two-Level Video Interrupt Aggregator

This block gathers single-cycle event pulses from nine video sources and turns them into interrupt lines. The sources are four output ports, four input pipelines and one write-back path. Each source owns a sticky second-level status register and a matching enable register. For every source, a first-level summary bit reports whether any enabled event of that source is pending. The summary is visible in two forms: a raw view, and a view gated by a first-level enable. That enable is changed through two addresses, one that sets bits and one that clears them.

Every event falls into one of three classes: functional, safety-diagnostic or security. The whole register set is copied for each of four host contexts. Each host gets its own functional, safety and security line, which makes twelve lines in total.

Event pulses are broadcast to all four hosts. Each host clears and masks them on its own. Software reaches every register through a simple write-strobe port with a combinational read-data path.

Top module: `irq_fabric`

## Requirements
- R1: After reset every register of every host reads 0 and all twelve interrupt lines are low.
- R2: An event pulse on a source input sets the matching second-level status bit in every host, whatever the enables hold. The bit stays set until software clears it.
- R3: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If an event for that bit arrives in the same cycle as the clear, the bit stays set.
- R4: The raw first-level bit of a source is 1 exactly when that source has a bit that is both pending and enabled at the second level. The first-level enable has no effect on the raw bit. Raw bit positions are:
  - bits 0 to 3 for output ports 1 to 4
  - bits 4 to 7 for input pipelines 1 to 4
  - bit 14 for the write-back path
- R5: Writing a 1 to index 2 sets first-level enable bits, and writing a 1 to index 3 clears them. Both indices read back the current enable. Index 1 reads the raw view AND the enable.
- R6: Each event bit is routed to exactly one class of line.
  - Output-port bits 6 to 9 and 13 to 16, and input-pipeline bit 2, go to the safety line.
  - Output-port bit 10 and write-back bit 3 go to the security line.
  - Every other valid bit goes to the functional line.
- R7: A host's line for a class is a registered level. It rises one clock after an event of that class becomes enabled and pending at both levels. It falls one clock after the last such condition goes away.
- R8: The hosts are independent. A register write to one host changes no register and no line of another host.
- R9: Reserved bits and reserved indices read as 0, and writes to them have no effect. Output-port bit 12 is reserved, so an event on it is ignored.
- R10: Addresses are 7 bits wide. Bits [6:5] select the host and bits [4:0] select the index:
  - 0: raw view
  - 1: masked view
  - 2 and 3: enable set and enable clear
  - 4 to 7: output-port status
  - 8 to 11: output-port enable
  - 12 to 15: pipeline status
  - 16 to 19: pipeline enable
  - 20: write-back status
  - 21: write-back enable

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_evt | input | 68 | Output-port event pulses, 17 per port, port n at bits [17n+16:17n] |
| pipe_evt | input | 20 | Input-pipeline event pulses, 5 per pipeline |
| wb_evt | input | 5 | Write-back event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (host, index) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_func | output | 4 | Functional line per host |
| irq_safe | output | 4 | Safety-diagnostic line per host |
| irq_sec | output | 4 | Security line per host |

## Verification
Two functions can meet in one cycle: an event pulse for a status bit, and a write-1-to-clear of that same bit. The bench drives the pulse and the clearing write on the same falling edge, so both are seen at the same rising edge. It then reads the bit back and expects it to be 1. A second clear with no event present must then read 0. Line rise and fall are also timed against the enable writes, with the line sampled both in the cycle where it must still hold its old value and in the cycle after.

// File: rtl/irq_fabric_pkg.sv
`timescale 1ns/1ps
package irq_fabric_pkg;
  localparam int NUM_HOSTS = 4;
  localparam int NUM_PORTS = 4;
  localparam int NUM_PIPES = 4;
  localparam int PORT_W    = 17;
  localparam int PIPE_W    = 5;
  localparam int WB_W      = 5;
  localparam int L1_W      = 15;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 5;
  localparam int HOST_W    = $clog2(NUM_HOSTS);
  localparam int ADDR_W    = HOST_W + IDX_W;

  // class masks per source kind
  localparam logic [PORT_W-1:0] PORT_VALID = 17'h1EFFF;
  localparam logic [PORT_W-1:0] PORT_SAFE  = 17'h1E3C0;
  localparam logic [PORT_W-1:0] PORT_SEC   = 17'h00400;
  localparam logic [PIPE_W-1:0] PIPE_VALID = 5'h1F;
  localparam logic [PIPE_W-1:0] PIPE_SAFE  = 5'h04;
  localparam logic [PIPE_W-1:0] PIPE_SEC   = 5'h00;
  localparam logic [WB_W-1:0]   WB_VALID   = 5'h1F;
  localparam logic [WB_W-1:0]   WB_SAFE    = 5'h00;
  localparam logic [WB_W-1:0]   WB_SEC     = 5'h08;

  // summary bit placement
  localparam int L1_PORT_BASE = 0;
  localparam int L1_PIPE_BASE = 4;
  localparam int L1_WB_BIT    = 14;
  localparam logic [L1_W-1:0] L1_VALID = 15'h40FF;

  // register indices inside one host window
  localparam int IDX_RAW     = 0;
  localparam int IDX_MASKED  = 1;
  localparam int IDX_EN_SET  = 2;
  localparam int IDX_EN_CLR  = 3;
  localparam int IDX_PORT_ST = 4;
  localparam int IDX_PORT_EN = IDX_PORT_ST + NUM_PORTS;
  localparam int IDX_PIPE_ST = IDX_PORT_EN + NUM_PORTS;
  localparam int IDX_PIPE_EN = IDX_PIPE_ST + NUM_PIPES;
  localparam int IDX_WB_ST   = IDX_PIPE_EN + NUM_PIPES;
  localparam int IDX_WB_EN   = IDX_WB_ST + 1;

  typedef struct packed {
    logic func;
    logic safe;
    logic sec;
  } cat_t;
endpackage

// File: rtl/irq_src_reg.sv
`timescale 1ns/1ps
module irq_src_reg
  import irq_fabric_pkg::*;
#(
  parameter int             W      = 5,
  parameter logic [W-1:0]   VALID  = '1,
  parameter logic [W-1:0]   SAFE_M = '0,
  parameter logic [W-1:0]   SEC_M  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         st_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output cat_t         pend,
  output logic         any
);
  localparam logic [W-1:0] FUNC_M = VALID & ~SAFE_M & ~SEC_M;

  logic [W-1:0] status_nxt;
  logic [W-1:0] enable_nxt;
  logic [W-1:0] active;
  logic         status_upd;

  always_comb begin
    status_upd = st_wr | (|(evt & VALID));
    status_nxt = status;
    if (st_wr) status_nxt = status_nxt & ~wdata;
    status_nxt = (status_nxt | evt) & VALID;   // event wins over clear
    enable_nxt = wdata & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      if (status_upd) status <= status_nxt;
      if (en_wr)      enable <= enable_nxt;
    end
  end

  assign active    = status & enable;
  assign pend.func = |(active & FUNC_M);
  assign pend.safe = |(active & SAFE_M);
  assign pend.sec  = |(active & SEC_M);
  assign any       = |active;

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & VALID)) |=> ((status & $past(evt & VALID)) == $past(evt & VALID))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((status & $past(wdata & ~evt)) == '0)); // R3
endmodule

// File: rtl/irq_host_ctx.sv
`timescale 1ns/1ps
module irq_host_ctx
  import irq_fabric_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] port_evt,
  input  logic [NUM_PIPES*PIPE_W-1:0] pipe_evt,
  input  logic [WB_W-1:0]             wb_evt,
  input  logic                        wr,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        irq_func,
  output logic                        irq_safe,
  output logic                        irq_sec
);
  logic [PORT_W-1:0] port_st [NUM_PORTS];
  logic [PORT_W-1:0] port_en [NUM_PORTS];
  cat_t              port_pend [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_any;
  logic [PIPE_W-1:0] pipe_st [NUM_PIPES];
  logic [PIPE_W-1:0] pipe_en [NUM_PIPES];
  cat_t              pipe_pend [NUM_PIPES];
  logic [NUM_PIPES-1:0] pipe_any;
  logic [WB_W-1:0]   wb_st, wb_en;
  cat_t              wb_pend;
  logic              wb_any;

  logic [L1_W-1:0] l1_en, l1_en_nxt, l1_raw, l1_masked;
  logic            l1_en_upd;
  logic            func_nxt, safe_nxt, sec_nxt;
  logic            unused_hi_bits;

  assign unused_hi_bits = ^wdata[DATA_W-1:PORT_W];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    irq_src_reg #(.W(PORT_W), .VALID(PORT_VALID), .SAFE_M(PORT_SAFE), .SEC_M(PORT_SEC)) u_src (
      .clk(clk), .rst_n(rst_n),
      .evt(port_evt[g*PORT_W +: PORT_W]),
      .st_wr(wr && int'(idx) == IDX_PORT_ST + g),
      .en_wr(wr && int'(idx) == IDX_PORT_EN + g),
      .wdata(wdata[PORT_W-1:0]),
      .status(port_st[g]), .enable(port_en[g]),
      .pend(port_pend[g]), .any(port_any[g]));
  end

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    irq_src_reg #(.W(PIPE_W), .VALID(PIPE_VALID), .SAFE_M(PIPE_SAFE), .SEC_M(PIPE_SEC)) u_src (
      .clk(clk), .rst_n(rst_n),
      .evt(pipe_evt[g*PIPE_W +: PIPE_W]),
      .st_wr(wr && int'(idx) == IDX_PIPE_ST + g),
      .en_wr(wr && int'(idx) == IDX_PIPE_EN + g),
      .wdata(wdata[PIPE_W-1:0]),
      .status(pipe_st[g]), .enable(pipe_en[g]),
      .pend(pipe_pend[g]), .any(pipe_any[g]));
  end

  irq_src_reg #(.W(WB_W), .VALID(WB_VALID), .SAFE_M(WB_SAFE), .SEC_M(WB_SEC)) u_wb (
    .clk(clk), .rst_n(rst_n), .evt(wb_evt),
    .st_wr(wr && int'(idx) == IDX_WB_ST),
    .en_wr(wr && int'(idx) == IDX_WB_EN),
    .wdata(wdata[WB_W-1:0]),
    .status(wb_st), .enable(wb_en), .pend(wb_pend), .any(wb_any));

  // first-level summary and line next-state
  always_comb begin
    l1_raw = '0;
    for (int p = 0; p < NUM_PORTS; p++) l1_raw[L1_PORT_BASE + p] = port_any[p];
    for (int q = 0; q < NUM_PIPES; q++) l1_raw[L1_PIPE_BASE + q] = pipe_any[q];
    l1_raw[L1_WB_BIT] = wb_any;
    l1_masked = l1_raw & l1_en;

    func_nxt = l1_en[L1_WB_BIT] & wb_pend.func;
    safe_nxt = l1_en[L1_WB_BIT] & wb_pend.safe;
    sec_nxt  = l1_en[L1_WB_BIT] & wb_pend.sec;
    for (int p = 0; p < NUM_PORTS; p++) begin
      func_nxt |= l1_en[L1_PORT_BASE + p] & port_pend[p].func;
      safe_nxt |= l1_en[L1_PORT_BASE + p] & port_pend[p].safe;
      sec_nxt  |= l1_en[L1_PORT_BASE + p] & port_pend[p].sec;
    end
    for (int q = 0; q < NUM_PIPES; q++) begin
      func_nxt |= l1_en[L1_PIPE_BASE + q] & pipe_pend[q].func;
      safe_nxt |= l1_en[L1_PIPE_BASE + q] & pipe_pend[q].safe;
      sec_nxt  |= l1_en[L1_PIPE_BASE + q] & pipe_pend[q].sec;
    end
  end

  // first-level enable via set / clear addresses
  always_comb begin
    l1_en_upd = wr && (int'(idx) == IDX_EN_SET || int'(idx) == IDX_EN_CLR);
    if (int'(idx) == IDX_EN_SET) l1_en_nxt = (l1_en | wdata[L1_W-1:0]) & L1_VALID;
    else                         l1_en_nxt = l1_en & ~wdata[L1_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_en    <= '0;
      irq_func <= 1'b0;
      irq_safe <= 1'b0;
      irq_sec  <= 1'b0;
    end else begin
      if (l1_en_upd) l1_en <= l1_en_nxt;
      irq_func <= func_nxt;
      irq_safe <= safe_nxt;
      irq_sec  <= sec_nxt;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (int'(idx) == IDX_RAW)    rdata[L1_W-1:0] = l1_raw;
    if (int'(idx) == IDX_MASKED) rdata[L1_W-1:0] = l1_masked;
    if (int'(idx) == IDX_EN_SET || int'(idx) == IDX_EN_CLR) rdata[L1_W-1:0] = l1_en;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(idx) == IDX_PORT_ST + p) rdata[PORT_W-1:0] = port_st[p];
      if (int'(idx) == IDX_PORT_EN + p) rdata[PORT_W-1:0] = port_en[p];
    end
    for (int q = 0; q < NUM_PIPES; q++) begin
      if (int'(idx) == IDX_PIPE_ST + q) rdata[PIPE_W-1:0] = pipe_st[q];
      if (int'(idx) == IDX_PIPE_EN + q) rdata[PIPE_W-1:0] = pipe_en[q];
    end
    if (int'(idx) == IDX_WB_ST) rdata[WB_W-1:0] = wb_st;
    if (int'(idx) == IDX_WB_EN) rdata[WB_W-1:0] = wb_en;
  end

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(idx) == IDX_EN_SET) |=>
      ((l1_en & $past(wdata[L1_W-1:0] & L1_VALID)) == $past(wdata[L1_W-1:0] & L1_VALID))); // R5
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(idx) == IDX_EN_CLR) |=> ((l1_en & $past(wdata[L1_W-1:0])) == '0)); // R5
  AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_masked == '0) |=> (!irq_func && !irq_safe && !irq_sec)); // R7
endmodule

// File: rtl/irq_fabric.sv
`timescale 1ns/1ps
module irq_fabric
  import irq_fabric_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] port_evt,
  input  logic [NUM_PIPES*PIPE_W-1:0] pipe_evt,
  input  logic [WB_W-1:0]             wb_evt,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [NUM_HOSTS-1:0]        irq_func,
  output logic [NUM_HOSTS-1:0]        irq_safe,
  output logic [NUM_HOSTS-1:0]        irq_sec
);
  logic [HOST_W-1:0] host_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] host_rdata [NUM_HOSTS];

  assign host_sel = reg_addr[ADDR_W-1:IDX_W];
  assign idx      = reg_addr[IDX_W-1:0];

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
    irq_host_ctx u_ctx (
      .clk(clk), .rst_n(rst_n),
      .port_evt(port_evt), .pipe_evt(pipe_evt), .wb_evt(wb_evt),
      .wr(reg_we && int'(host_sel) == h),
      .idx(idx), .wdata(reg_wdata), .rdata(host_rdata[h]),
      .irq_func(irq_func[h]), .irq_safe(irq_safe[h]), .irq_sec(irq_sec[h]));
  end

  assign reg_rdata = host_rdata[host_sel];
endmodule

// File: tb/irq_fabric_tb.sv
`timescale 1ns/1ps
module irq_fabric_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [67:0] port_evt;
  logic [19:0] pipe_evt;
  logic [4:0]  wb_evt;
  logic        reg_we;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_func, irq_safe, irq_sec;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_fabric u_dut (
    .clk(clk), .rst_n(rst_n), .port_evt(port_evt), .pipe_evt(pipe_evt), .wb_evt(wb_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_func(irq_func), .irq_safe(irq_safe), .irq_sec(irq_sec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int h, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'((h << 5) | idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int h, input int idx, output logic [31:0] d);
    reg_addr = 7'((h << 5) | idx);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] lines(input int h);
    return {29'b0, irq_func[h], irq_safe[h], irq_sec[h]};
  endfunction

  // {func,safe,sec} class of a source bit; s: 0-3 ports, 4-7 pipes, 8 write-back
  function automatic logic [31:0] exp_cat(input int s, input int b);
    if (s < 4) begin
      if ((b >= 6 && b <= 9) || (b >= 13 && b <= 16)) return 32'd2;
      if (b == 10) return 32'd1;
      return 32'd4;
    end else if (s < 8) return (b == 2) ? 32'd2 : 32'd4;
    return (b == 3) ? 32'd1 : 32'd4;
  endfunction

  function automatic int st_idx(input int s);
    return (s < 4) ? 4 + s : (s < 8) ? 12 + (s - 4) : 20;
  endfunction
  function automatic int en_idx(input int s);
    return (s < 4) ? 8 + s : (s < 8) ? 16 + (s - 4) : 21;
  endfunction
  function automatic int l1_bit(input int s);
    return (s < 8) ? s : 14;
  endfunction

  task automatic pulse(input int s, input int b);
    @(negedge clk);
    if (s < 4) port_evt[s*17 + b] = 1'b1;
    else if (s < 8) pipe_evt[(s-4)*5 + b] = 1'b1;
    else wb_evt[b] = 1'b1;
    @(negedge clk);
    port_evt = '0; pipe_evt = '0; wb_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; port_evt = '0; pipe_evt = '0; wb_evt = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int h = 0; h < 4; h++) begin
      for (int i = 0; i < 32; i++) begin
        rd(h, i, d); chk("R1 reset register", d, 32'd0);
      end
      chk("R1 reset lines", lines(h), 32'd0);
    end

    // sweep every valid source bit across every host (R2,R4,R5,R6,R7,R8,R10)
    for (int s = 0; s < 9; s++) begin
      for (int b = 0; b < ((s < 4) ? 17 : 5); b++) begin
        if (s < 4 && b == 12) continue;
        pulse(s, b);
        for (int h = 0; h < 4; h++) begin
          rd(h, st_idx(s), d); chk("R2 sticky status", d, 32'd1 << b);
          rd(h, 0, d);         chk("R4 raw needs L2 enable", d, 32'd0);
          chk("R6 no line without enable", lines(h), 32'd0);
        end
        for (int h = 0; h < 4; h++) begin
          wr(h, en_idx(s), 32'd1 << b);
          wr(h, 2, 32'd1 << l1_bit(s));
          chk("R7 line not yet high", lines(h), 32'd0);
          @(negedge clk); #1;
          chk("R6 class routing", lines(h), exp_cat(s, b));
          for (int o = 0; o < 4; o++)
            if (o != h) chk("R8 other host quiet", lines(o), 32'd0);
          rd(h, 0, d); chk("R4 raw summary", d, 32'd1 << l1_bit(s));
          rd(h, 1, d); chk("R5 masked view", d, 32'd1 << l1_bit(s));
          rd(h, 2, d); chk("R5 set readback", d, 32'd1 << l1_bit(s));
          wr(h, 3, 32'd1 << l1_bit(s));
          chk("R7 line holds one cycle", lines(h), exp_cat(s, b));
          @(negedge clk); #1;
          chk("R7 line falls", lines(h), 32'd0);
          rd(h, 0, d); chk("R4 raw ignores L1 enable", d, 32'd1 << l1_bit(s));
          rd(h, 1, d); chk("R5 masked after clear", d, 32'd0);
          wr(h, en_idx(s), 32'd0);
          rd(h, 0, d); chk("R4 raw after L2 disable", d, 32'd0);
        end
        for (int h = 0; h < 4; h++) begin
          wr(h, st_idx(s), 32'd1 << b);
          rd(h, st_idx(s), d); chk("R3 write one clears", d, 32'd0);
        end
      end
    end

    // R3: event and clear in the same cycle
    @(negedge clk);
    port_evt[0] = 1'b1; reg_we = 1'b1; reg_addr = 7'd4; reg_wdata = 32'd1;
    @(negedge clk);
    port_evt = '0; reg_we = 1'b0;
    rd(0, 4, d); chk("R3 event wins over clear", d, 32'd1);
    wr(0, 4, 32'd0);
    rd(0, 4, d); chk("R3 write zero keeps bit", d, 32'd1);
    for (int h = 0; h < 4; h++) wr(h, 4, 32'hFFFF_FFFF);
    rd(0, 4, d); chk("R3 clear without event", d, 32'd0);

    // R9: reserved bits and indices
    wr(2, 8, 32'hFFFF_FFFF);
    rd(2, 8, d); chk("R9 port enable reserved bits", d, 32'h0001_EFFF);
    wr(2, 2, 32'hFFFF_FFFF);
    rd(2, 2, d); chk("R9 L1 enable reserved bits", d, 32'h0000_40FF);
    rd(2, 3, d); chk("R5 clr index reads enable", d, 32'h0000_40FF);
    rd(1, 8, d); chk("R8 host isolation", d, 32'd0);
    rd(1, 2, d); chk("R8 host isolation L1", d, 32'd0);
    pulse(0, 12);
    rd(2, 4, d); chk("R9 reserved event ignored", d, 32'd0);
    @(negedge clk); #1;
    chk("R9 reserved event no line", lines(2), 32'd0);
    wr(2, 25, 32'hFFFF_FFFF);
    rd(2, 25, d); chk("R9 reserved index reads zero", d, 32'd0);
    wr(2, 3, 32'hFFFF_FFFF);
    rd(2, 2, d); chk("R5 clear all", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule